// File: doc/BRIEF.md
# Dual Comparator Fault Monitor

This block is the digital side of a two-channel supply monitor. Each channel arrives as an asynchronous "input above threshold" flag from an analog comparator. The block resynchronises each flag and reads it as an undervoltage or an overvoltage fault, depending on a per-channel mode bit. When any channel is in fault it drives an active-low fault line, which the pad treats as an open-drain pull-down. A configuration bit can keep the fault line released while the supply is being margined.

A status word gives the host the live fault state of both channels, plus a held snapshot of those states. The snapshot is taken on one of two selectable events. The first is the fault line going active. The second is a falling edge on a shared ready line that other devices can pull low. The second event lets several monitors freeze their channel states at the same instant. The host clears held bits by pulsing a clear strobe with a per-channel select.

All control and status pins are plain levels. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `dual_cmp_fault_monitor`

## Requirements
- R1: During reset and until the synchronisers have filled after reset, `fault_n_o` is 1 and all bits of `status_o` are 0.
- R2: A channel whose `cfg_ov_i` bit is 0 (undervoltage mode) is in fault while its comparator flag is 0. Its live bit `status_o[c]` reads 1 for fault and 0 for no fault.
- R3: A channel whose `cfg_ov_i` bit is 1 (overvoltage mode) is in fault while its comparator flag is 1. A mode change takes effect on the live bit in the same cycle.
- R4: A comparator flag change applied before clock edge k shows on the live bit after edge k+1 (two-flop synchroniser). It shows on `fault_n_o` after edge k+2.
- R5: `fault_n_o` is 0 for as long as at least one live bit is 1 and suppression is off. It returns to 1 one cycle after all live bits clear.
- R6: While `cfg_mask_margin_i` and `margin_active_i` are both 1, `fault_n_o` stays 1. The live bits still report faults.
- R7: With `cfg_snap_on_ready_i` = 0, the held bits `status_o[NCH+c]` load the live bits at the edge where `fault_n_o` goes from 1 to 0. The held bits do not reload while `fault_n_o` stays 0.
- R8: With `cfg_snap_on_ready_i` = 1 and `cfg_ready_act_high_i` = 1, a falling edge on `ready_line_i` loads the live bits into the held bits. The load happens three clock edges after the line falls, because the line goes through two synchroniser flops and one edge-detect flop.
- R9: A falling edge on `ready_line_i` has no effect on the held bits when `cfg_ready_act_high_i` is 0 or `cfg_snap_on_ready_i` is 0.
- R10: Held bits keep their value until a cycle with `clr_i` = 1 clears the bits selected by `clr_sel_i`. If a snapshot load and a clear fall in the same cycle, the load wins.
- R11: When suppression keeps `fault_n_o` at 1, no fault-line snapshot is taken. Releasing suppression while a fault persists asserts `fault_n_o` and takes a snapshot at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_above_i | input | NCH | Asynchronous per-channel comparator flag, 1 = above threshold |
| ready_line_i | input | 1 | Sampled level of the shared ready line (asynchronous) |
| cfg_ov_i | input | NCH | Per-channel mode: 0 undervoltage, 1 overvoltage |
| cfg_mask_margin_i | input | 1 | Suppress the fault line during margining |
| margin_active_i | input | 1 | Margining in progress |
| cfg_snap_on_ready_i | input | 1 | Snapshot source: 0 fault line asserting, 1 ready line falling |
| cfg_ready_act_high_i | input | 1 | Ready line configured active high (allows its use as an input) |
| clr_i | input | 1 | Clear strobe for held bits |
| clr_sel_i | input | NCH | Per-channel select for the clear strobe |
| fault_n_o | output | 1 | Active-low fault line (0 = pull low) |
| status_o | output | 2*NCH | [NCH-1:0] live fault bits, [2*NCH-1:NCH] held bits |

## Verification
The bench builds the block with NCH = 2 and SYNC_STAGES = 2. With these values the two channels can sit in opposite polarity modes at the same time, and the snapshot can catch a mixed pattern. Every latency is a short, exact count of edges, so directed checks land on the precise edge where the live bits, the fault line and the held bits change. A random phase then toggles flags, modes, suppression, snapshot source and clears together, and compares each cycle with a bench model built from the requirements.

// File: rtl/fmon_pkg.sv
package fmon_pkg;
  typedef enum logic {
    SNAP_ON_FAULT = 1'b0,
    SNAP_ON_READY = 1'b1
  } snap_src_e;

  localparam int DEF_NCH    = 2;
  localparam int DEF_STAGES = 2;
endpackage

// File: rtl/fmon_sync.sv
module fmon_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         primed_o
);
  localparam int CW = $clog2(STAGES + 1);

  logic [W-1:0]  pipe_q [STAGES];
  logic [CW-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
      fill_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      if (fill_q != CW'(STAGES)) fill_q <= fill_q + 1'b1;
    end
  end

  assign q_o      = pipe_q[STAGES-1];
  assign primed_o = (fill_q == CW'(STAGES));

  // R4: once filled, the pipeline stays valid until the next reset
  assert_primed_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_o |=> primed_o);
endmodule

// File: rtl/fmon_polarity.sv
module fmon_polarity #(
  parameter int NCH = 2
) (
  input  logic           primed_i,
  input  logic [NCH-1:0] above_i,
  input  logic [NCH-1:0] ov_mode_i,
  output logic [NCH-1:0] fault_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign fault_o[c] = primed_i & (ov_mode_i[c] ? above_i[c] : ~above_i[c]);
  end
endmodule

// File: rtl/fmon_snapshot.sv
module fmon_snapshot #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           capture_i,
  input  logic [NCH-1:0] live_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] clr_sel_i,
  output logic [NCH-1:0] held_o
);
  logic [NCH-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        held_q <= '0;
    else if (capture_i) held_q <= live_i;
    else if (clr_i)     held_q <= held_q & ~clr_sel_i;
  end

  assign held_o = held_q;

  assert_held_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !clr_i) |=> $stable(held_o));

  assert_clear_effect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !capture_i) |=> ((held_o & $past(clr_sel_i)) == '0));
endmodule

// File: rtl/dual_cmp_fault_monitor.sv
module dual_cmp_fault_monitor
  import fmon_pkg::*;
#(
  parameter int NCH         = DEF_NCH,
  parameter int SYNC_STAGES = DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   cmp_above_i,
  input  logic             ready_line_i,
  input  logic [NCH-1:0]   cfg_ov_i,
  input  logic             cfg_mask_margin_i,
  input  logic             margin_active_i,
  input  logic             cfg_snap_on_ready_i,
  input  logic             cfg_ready_act_high_i,
  input  logic             clr_i,
  input  logic [NCH-1:0]   clr_sel_i,
  output logic             fault_n_o,
  output logic [2*NCH-1:0] status_o
);
  localparam int SW = 2 * NCH;

  logic [NCH-1:0] cmp_s, live, held;
  logic           cmp_primed, rdy_s, rdy_primed, rdy_prev_q;
  logic           suppress, drive_next, fault_act_q;
  logic           evt_fault, evt_ready;
  snap_src_e      snap_src;

  fmon_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cmp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_above_i),
    .q_o(cmp_s), .primed_o(cmp_primed));

  fmon_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ready_line_i),
    .q_o(rdy_s), .primed_o(rdy_primed));

  fmon_polarity #(.NCH(NCH)) u_pol (
    .primed_i(cmp_primed), .above_i(cmp_s), .ov_mode_i(cfg_ov_i), .fault_o(live));

  assign snap_src   = snap_src_e'(cfg_snap_on_ready_i);
  assign suppress   = cfg_mask_margin_i & margin_active_i;
  assign drive_next = (|live) & ~suppress;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_act_q <= 1'b0;
      rdy_prev_q  <= 1'b1;
    end else begin
      fault_act_q <= drive_next;
      rdy_prev_q  <= rdy_s;
    end
  end

  assign evt_fault = (snap_src == SNAP_ON_FAULT) & drive_next & ~fault_act_q;
  assign evt_ready = (snap_src == SNAP_ON_READY) & cfg_ready_act_high_i &
                     rdy_primed & rdy_prev_q & ~rdy_s;

  fmon_snapshot #(.NCH(NCH)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .capture_i(evt_fault | evt_ready),
    .live_i(live), .clr_i(clr_i), .clr_sel_i(clr_sel_i), .held_o(held));

  assign fault_n_o = ~fault_act_q;
  assign status_o  = SW'({held, live});

  assert_mask_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mask_margin_i && margin_active_i) |=> fault_n_o);

  assert_fault_has_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_n_o) |-> $past(|status_o[NCH-1:0]));

  assert_ready_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_snap_on_ready_i && !cfg_ready_act_high_i && !clr_i)
      |=> $stable(status_o[SW-1:NCH]));

  assert_fault_snap_needs_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_snap_on_ready_i && !fault_n_o && !clr_i) |=> $stable(status_o[SW-1:NCH]));
endmodule

// File: tb/tb_dual_cmp_fault_monitor.sv
module tb_dual_cmp_fault_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] cmp, cfg_ov, clr_sel;
  logic ready, mask, marg, sel, ah, clr;
  logic fault_n;
  logic [2*NCH-1:0] status;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmp_fault_monitor #(.NCH(NCH), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_above_i(cmp), .ready_line_i(ready),
    .cfg_ov_i(cfg_ov), .cfg_mask_margin_i(mask), .margin_active_i(marg),
    .cfg_snap_on_ready_i(sel), .cfg_ready_act_high_i(ah), .clr_i(clr),
    .clr_sel_i(clr_sel), .fault_n_o(fault_n), .status_o(status));

  function automatic logic [NCH-1:0] exp_live(logic [NCH-1:0] above, logic [NCH-1:0] ov);
    for (int c = 0; c < NCH; c++) exp_live[c] = ov[c] ? above[c] : ~above[c];
  endfunction

  // reference model built from the requirements
  logic [NCH-1:0] m_s1, m_s2, m_held;
  logic m_r1, m_r2, m_r3, m_act;
  int m_fill;
  always @(posedge clk) begin : model
    logic [NCH-1:0] lv;
    logic drv, evt;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_held <= '0; m_r1 <= 1; m_r2 <= 1; m_r3 <= 1;
      m_act <= 0; m_fill <= 0;
    end else begin
      lv  = (m_fill >= 2) ? exp_live(m_s2, cfg_ov) : '0;
      drv = (|lv) && !(mask && marg);
      evt = (!sel && drv && !m_act) || (sel && ah && (m_fill >= 2) && m_r3 && !m_r2);
      if (evt) m_held <= lv;
      else if (clr) m_held <= m_held & ~clr_sel;
      m_act <= drv;
      m_s1 <= cmp; m_s2 <= m_s1; m_r1 <= ready; m_r2 <= m_r1; m_r3 <= m_r2;
      if (m_fill < 2) m_fill <= m_fill + 1;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(logic [NCH-1:0] s);
    clr = 1; clr_sel = s; waitn(1); clr = 0; clr_sel = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd20240611);
    cmp = 2'b11; cfg_ov = 2'b00; ready = 1; mask = 0; marg = 0; sel = 0; ah = 0;
    clr = 0; clr_sel = '0;
    waitn(3);
    chk("R1 fault_n in reset", 8'(fault_n), 8'd1);
    chk("R1 status in reset", 8'(status), 8'd0);
    rst_n = 1;
    waitn(1);
    chk("R1 status before fill", 8'(status), 8'd0);
    waitn(3);
    chk("R1 idle fault_n", 8'(fault_n), 8'd1);
    chk("R1 idle status", 8'(status), 8'd0);

    // R2 / R4: channel 0 drops below threshold in UV mode
    cmp = 2'b10;
    waitn(1); chk("R4 live not yet", 8'(status[1:0]), 8'd0);
    waitn(1); chk("R2 R4 live after sync", 8'(status[1:0]), 8'b01);
    chk("R4 fault_n not yet", 8'(fault_n), 8'd1);
    waitn(1); chk("R5 fault_n asserted", 8'(fault_n), 8'd0);
    chk("R7 snapshot on fault edge", 8'(status[3:2]), 8'b01);
    cmp = 2'b00;
    waitn(3); chk("R2 both live", 8'(status[1:0]), 8'b11);
    chk("R7 no reload while asserted", 8'(status[3:2]), 8'b01);
    chk("R5 fault_n held", 8'(fault_n), 8'd0);
    pulse_clr(2'b01);
    chk("R10 cleared", 8'(status[3:2]), 8'b00);
    waitn(2); chk("R10 stays cleared", 8'(status[3:2]), 8'b00);
    cmp = 2'b11;
    waitn(3); chk("R5 fault_n released", 8'(fault_n), 8'd1);
    chk("R5 live clear", 8'(status[1:0]), 8'd0);

    // R3: channel 1 in OV mode, flag high
    cfg_ov = 2'b10;
    #1 chk("R3 mode change same cycle", 8'(status[1:0]), 8'b10);
    waitn(1); chk("R3 fault_n", 8'(fault_n), 8'd0);
    chk("R7 snapshot ov", 8'(status[3:2]), 8'b10);
    cmp = 2'b01;
    waitn(2); chk("R3 ov cleared", 8'(status[1:0]), 8'b00);
    waitn(1); chk("R5 release", 8'(fault_n), 8'd1);

    // R6 / R11: suppression while margining
    cfg_ov = 2'b00; mask = 1; marg = 1; cmp = 2'b00;
    waitn(4); chk("R6 live reported", 8'(status[1:0]), 8'b11);
    chk("R6 fault_n suppressed", 8'(fault_n), 8'd1);
    chk("R11 no snapshot while suppressed", 8'(status[3:2]), 8'b10);
    marg = 0;
    waitn(1); chk("R11 fault_n on release", 8'(fault_n), 8'd0);
    chk("R11 snapshot on release", 8'(status[3:2]), 8'b11);
    marg = 1;
    waitn(1); chk("R6 suppress again", 8'(fault_n), 8'd1);

    // R8: ready-line snapshot
    sel = 1; ah = 1;
    pulse_clr(2'b11);
    ready = 0;
    waitn(2); chk("R8 not yet", 8'(status[3:2]), 8'b00);
    waitn(1); chk("R8 ready snapshot", 8'(status[3:2]), 8'b11);
    ready = 1; cmp = 2'b01;
    waitn(3); pulse_clr(2'b11);

    // R9: ready edges ignored
    ah = 0; ready = 0;
    waitn(4); chk("R9 active-low ready ignored", 8'(status[3:2]), 8'b00);
    ready = 1; waitn(3);
    ah = 1; sel = 0; ready = 0;
    waitn(4); chk("R9 fault source ignores ready", 8'(status[3:2]), 8'b00);
    ready = 1; sel = 1; waitn(3);

    // R10: load beats clear in the same cycle
    ready = 0;
    waitn(2); clr = 1; clr_sel = 2'b11;
    waitn(1); clr = 0; clr_sel = '0;
    chk("R10 capture wins", 8'(status[3:2]), 8'b10);
    ready = 1; waitn(3);

    // random phase against the model
    mask = 0; marg = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R5 R6 random fault_n", 8'(fault_n), 8'(!m_act));
      chk("R2 R3 R4 random live", 8'(status[1:0]),
          8'((m_fill >= 2) ? exp_live(m_s2, cfg_ov) : 2'b00));
      chk("R7 R8 R10 random held", 8'(status[3:2]), 8'(m_held));
      if ($urandom_range(7) == 0) cmp[0] = ~cmp[0];
      if ($urandom_range(7) == 0) cmp[1] = ~cmp[1];
      if ($urandom_range(63) == 0) cfg_ov = 2'($urandom);
      if ($urandom_range(63) == 0) mask = ~mask;
      if ($urandom_range(31) == 0) marg = ~marg;
      if ($urandom_range(63) == 0) sel = ~sel;
      if ($urandom_range(63) == 0) ah = ~ah;
      if ($urandom_range(15) == 0) ready = ~ready;
      clr = ($urandom_range(15) == 0);
      clr_sel = 2'($urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule